// File: doc/BRIEF.md
# Program Register File with Null Identifier

This block stores the general-purpose registers of a small 32-bit processor core. It keeps eight word-wide registers and serves three accesses per cycle: two reads, each with its own identifier and data output, and one write with its own identifier and data input. The decode stage drives the read identifiers, and the write-back stage drives the write identifier and data.

Identifiers are four bits wide, so not every code names a real register. Codes 0 through 7 select registers. Code F is reserved as the "no register" code, and a stage uses it when it has nothing to read or write. Codes 8 through E select nothing and are treated like F. A read is a pure function of its identifier and of the stored contents, with no clock involved. A write lands only at the rising clock edge, so a read of the register being written sees the old contents until that edge.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to 0, and any write presented in that cycle is discarded. After reset is released, every read of identifiers 0 to 7 returns 0.
- R2: When `rd_a_id` is in 0 to 7, `rd_a_data` equals the contents of that register in the same cycle, with no clock edge needed.
- R3: Read port B (`rd_b_id`, `rd_b_data`) behaves like port A and is independent of it. Any pair of identifiers may be read at the same time, the same identifier included.
- R4: When `wr_id` is in 0 to 7 at a rising edge with `rst` low, that register takes `wr_data` and every other register keeps its value.
- R5: A write with `wr_id` = F changes no register.
- R6: A write with `wr_id` in 8 to E changes no register.
- R7: A read with identifier F returns 0 on that port.
- R8: A read with an identifier in 8 to E returns 0 on that port.
- R9: While a write to register k is pending, a read of k on either port returns the old contents. The new value appears on the read port only after the rising edge.
- R10: The register identifiers have a fixed meaning, which the bench relies on: 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 frame pointer, 6 source index, 7 destination index. Register k is held at index k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_a_id | input | 4 | Read port A identifier (F = no read) |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_id | input | 4 | Read port B identifier (F = no read) |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_id | input | 4 | Write identifier (F = no write) |
| wr_data | input | 32 | Write data |

## Verification
The assertions check on every cycle that:
- the write enables are one-hot or idle;
- an identifier that is not a register never enables a write;
- a selected register takes the write data at the edge, and an unselected register holds its value;
- reads of F or of 8 to E return 0;
- the bank is all zero after reset is released.

Only the bench scenarios can show that read data matches a model across every pair of identifiers. The same applies to the old-versus-new ordering when a register is read and written in one cycle, and to a write being discarded during reset.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_ID_W     = 4;
  localparam int unsigned DEF_NUM_REGS = 8;
  localparam logic [3:0]  DEF_NULL_ID  = 4'hF;

  // Identifier meaning (R10)
  localparam logic [3:0] ID_ACC = 4'h0;
  localparam logic [3:0] ID_CNT = 4'h1;
  localparam logic [3:0] ID_DAT = 4'h2;
  localparam logic [3:0] ID_BAS = 4'h3;
  localparam logic [3:0] ID_SP  = 4'h4;
  localparam logic [3:0] ID_FP  = 4'h5;
  localparam logic [3:0] ID_SRC = 4'h6;
  localparam logic [3:0] ID_DST = 4'h7;
endpackage

// File: rtl/gpr_id_check.sv
module gpr_id_check #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [ID_W-1:0] NULL_ID = '1,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ID_W-1:0]  id,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_REGS);

  always_comb begin
    hit = (id != NULL_ID) && ({1'b0, id} < LIMIT);
    idx = id[IDX_W-1:0];
  end
endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] we
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    assign we[g] = hit && (idx == IDX_W'(g));
  end

  // R4: at most one register is selected per cycle
  p_onehot_we_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              we,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (we[g]) q[g] <= wdata;
    end

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> (q[g] == $past(wdata)));

    p_hold_unselected_r5: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(q[g]));
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == '0));
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [ID_W-1:0] NULL_ID = '1
) (
  input  logic [ID_W-1:0]                  id,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  bank,
  output logic [DATA_W-1:0]                data
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic             hit;
  logic [IDX_W-1:0] idx;

  gpr_id_check #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_chk (
    .id  (id),
    .hit (hit),
    .idx (idx)
  );

  always_comb begin
    data = '0;
    if (hit) data = bank[idx];
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned DATA_W   = gpr_pkg::DEF_DATA_W,
  parameter int unsigned ID_W     = gpr_pkg::DEF_ID_W,
  parameter int unsigned NUM_REGS = gpr_pkg::DEF_NUM_REGS,
  parameter logic [ID_W-1:0] NULL_ID = ID_W'(gpr_pkg::DEF_NULL_ID)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned   IDX_W = $clog2(NUM_REGS);
  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [NUM_REGS-1:0]             wr_en;
  logic                            wr_hit;
  logic [IDX_W-1:0]                wr_idx;

  gpr_id_check #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_wr_chk (
    .id  (wr_id),
    .hit (wr_hit),
    .idx (wr_idx)
  );

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_wr_dec (
    .clk (clk),
    .rst (rst),
    .hit (wr_hit),
    .idx (wr_idx),
    .we  (wr_en)
  );

  gpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .wdata (wr_data),
    .q     (bank_q)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_rd_a (
    .id   (rd_a_id),
    .bank (bank_q),
    .data (rd_a_data)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS), .NULL_ID(NULL_ID)) u_rd_b (
    .id   (rd_b_id),
    .bank (bank_q),
    .data (rd_b_data)
  );

  // R5, R6: identifiers that name no register never enable a write
  p_no_write_bad_id_r6: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, wr_id} >= LIMIT) || (wr_id == NULL_ID)) |-> (wr_en == '0));

  // R7: null identifier reads as zero on both ports
  p_null_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_id == NULL_ID) |-> (rd_a_data == '0)) and
    ((rd_b_id == NULL_ID) |-> (rd_b_data == '0)));

  // R8: identifiers past the last register read as zero
  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, rd_a_id} >= LIMIT) |-> (rd_a_data == '0)) and
    (({1'b0, rd_b_id} >= LIMIT) |-> (rd_b_data == '0)));
endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_id = 4'hF;
  logic [3:0]  rd_b_id = 4'hF;
  logic [3:0]  wr_id = 4'hF;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [8];

  gpr_file u_dut (
    .clk       (clk),
    .rst       (rst),
    .rd_a_id   (rd_a_id),
    .rd_a_data (rd_a_data),
    .rd_b_id   (rd_b_id),
    .rd_b_data (rd_b_data),
    .wr_id     (wr_id),
    .wr_data   (wr_data)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] expect_of(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_pair(input string req, input logic [3:0] a, input logic [3:0] b);
    rd_a_id = a;
    rd_b_id = b;
    #1;
    check(req, rd_a_data, expect_of(a));
    check(req, rd_b_data, expect_of(b));
  endtask

  task automatic write_reg(input logic [3:0] id, input logic [31:0] d);
    @(negedge clk);
    wr_id   = id;
    wr_data = d;
    @(negedge clk);
    wr_id = 4'hF;
    if (id < 4'd8) model[id[2:0]] = d;
  endtask

  task automatic sweep_all(input string req);
    for (int i = 0; i < 16; i++) read_pair(req, 4'(i), 4'(15 - i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;

    // R1: a write presented during reset is discarded
    wr_id = 4'h3;
    wr_data = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_id = 4'hF;
    for (int i = 0; i < 8; i++) read_pair("R1", 4'(i), 4'(i));

    // R4, R10: fill each register with an index-tagged value
    for (int i = 0; i < 8; i++)
      write_reg(4'(i), 32'h1111_1111 * (i + 1) ^ 32'hA5A5_0000);
    for (int i = 0; i < 8; i++) read_pair("R10", 4'(i), 4'(i));

    // R2, R3, R7, R8: every pair of read identifiers
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        read_pair((a == 15 || b == 15) ? "R7" :
                  (a > 7 || b > 7) ? "R8" : "R3", 4'(a), 4'(b));

    // R2: port A follows its identifier with no clock edge in between
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd_a_id = 4'(i);
      #0.5;
      check("R2", rd_a_data, model[i]);
    end

    // R5: null write changes nothing
    write_reg(4'hF, 32'h0BAD_0BAD);
    sweep_all("R5");

    // R6: writes with 8..E change nothing
    for (int k = 8; k < 15; k++) begin
      write_reg(4'(k), 32'hC0DE_0000 + k);
      for (int i = 0; i < 8; i++) read_pair("R6", 4'(i), 4'(i));
    end

    // R4: walking write; each write touches only its own register
    for (int i = 0; i < 8; i++) begin
      write_reg(4'(i), ~model[i]);
      for (int j = 0; j < 8; j++) read_pair("R4", 4'(j), 4'(7 - j));
    end

    // R9: read the register being written, on both ports
    @(negedge clk);
    wr_id   = gpr_pkg::ID_FP;
    wr_data = 32'h5555_AAAA;
    rd_a_id = gpr_pkg::ID_FP;
    rd_b_id = gpr_pkg::ID_FP;
    #1;
    check("R9", rd_a_data, model[5]);
    check("R9", rd_b_data, model[5]);
    @(posedge clk);
    #1;
    check("R9", rd_a_data, 32'h5555_AAAA);
    check("R9", rd_b_data, 32'h5555_AAAA);
    model[5] = 32'h5555_AAAA;
    @(negedge clk);
    wr_id = 4'hF;

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    sweep_all("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule